// File: doc/BRIEF.md
# Byte-to-Word Packet Stream Packer

This block sits between a byte-serial packet source and the 32-bit streaming transmit port of an Ethernet MAC. Each incoming byte carries a valid qualifier and a last-byte marker. The block gathers four bytes into one output word, with the earliest byte in the most significant lane. It marks the first and final words of each packet, and it reports how many trailing lanes of the final word hold no data. Backpressure from the MAC side stalls the byte input through its own ready signal. The output is never dropped.

A configuration input selects a 32-bit alignment mode. In this mode the downstream MAC throws away the upper half of the first word. The packer therefore puts two zero filler bytes there and starts the payload in the third lane. The block also caps the payload at a maximum length. A longer packet is cut short with an end marker and a one-cycle error pulse, and the rest of its bytes are taken in and dropped. Framing, CRC, minimum-length padding and the receive direction are handled elsewhere.

Top module: `byte_word_packer`

## Requirements
- R1: Bytes are packed most significant first. Byte k of a word (k = 0..3) sits in bits [31-8k -: 8], so the bytes 0x11, 0x22, 0x33, 0x44 give the word 0x11223344.
- R2: `out_sop` is 1 only on the first accepted word of a packet, and `out_eop` is 1 only on its last. Middle words carry neither flag.
- R3: A packet that fits in one word (at most 4 bytes, counting any filler) is sent as a single word with `out_sop` and `out_eop` both 1.
- R4: On an end word, `out_empty` equals the number of unused trailing lanes (3 valid bytes give 1, a full word gives 0), and the unused lanes read 0x00. On every valid word without `out_eop`, `out_empty` is 0.
- R5: When `align_en` is 1 at a packet's first byte, the first word has 0x00 in bits 31:16 and the first payload byte in bits 15:8. When `align_en` is 0, the payload starts at bits 31:24.
- R6: The payload limit is MAX_BYTES (default 1500). Filler bytes do not count toward it. A packet whose last byte is exactly the limit byte ends normally, with no error.
- R7: If the limit byte arrives without the last marker, the packer closes the packet with `out_eop` on the word holding that byte. It drives `oversize_err` high for exactly one cycle, namely the first cycle in which that word is presented. It then accepts and drops every further byte up to and including the one marked last.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output word, flags and empty count stay unchanged. Outside the dropping phase, `in_ready` is 0 during such a stall.
- R9: The first byte of a new packet may follow the last byte of the previous one in the next cycle with no gap. A synchronous `rst` discards any partly filled word and restarts packet tracking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| align_en | input | 1 | Alignment mode: insert two filler bytes before the payload |
| in_data | input | 8 | Incoming payload byte |
| in_valid | input | 1 | Byte is present |
| in_last | input | 1 | Byte is the final one of its packet |
| in_ready | output | 1 | Byte is taken when in_valid is also 1 |
| out_data | output | 32 | Packed word, earliest byte in bits 31:24 |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_empty | output | 2 | Unused trailing lanes on the last word |
| out_valid | output | 1 | Word is presented |
| out_ready | input | 1 | Downstream accepts the word |
| oversize_err | output | 1 | One-cycle pulse when a packet is truncated at the limit |

## Verification
Payload lengths from 1 to 9 bytes are sent with alignment off and then on. Together they step the final lane through every position, so a wrong empty count or a wrong lane order shows up for each residue. The aligned runs also separate single-word packets from those pushed into a second word by the filler. A periodically deasserted ready exposes any word that changes or is lost during a stall. Back-to-back packets show whether the start flag and lane index re-arm at a packet boundary. The length cases (exactly the limit, the limit with filler, and several bytes past the limit) distinguish a clean end from a truncation with an error. A reset issued mid-word shows whether stale lanes leak into the next packet.

// File: rtl/pkr_pkg.sv
package pkr_pkg;
    localparam int LANES    = 4;
    localparam int LANE_W   = 8;
    localparam int WORD_W   = LANES * LANE_W;
    localparam int LANE_IW  = $clog2(LANES);
    localparam int FILL_LANES = 2;

    typedef logic [LANE_IW-1:0] lane_idx_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              sop;
        logic              eop;
        lane_idx_t         empty;
    } pkr_word_t;

    function automatic lane_idx_t unused_lanes(input lane_idx_t final_lane);
        return lane_idx_t'(LANES - 1) - final_lane;
    endfunction
endpackage

// File: rtl/pkr_len_guard.sv
module pkr_len_guard #(
    parameter int MAX_BYTES = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic byte_fire,
    input  logic pay_fire,
    input  logic in_last,
    output logic at_limit,
    output logic discard,
    output logic err
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             cut_now;

    assign at_limit = (cnt_q == CNT_W'(MAX_BYTES - 1));
    assign cut_now  = pay_fire && at_limit && !in_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            discard <= 1'b0;
            err     <= 1'b0;
        end else begin
            err <= cut_now;
            if (pay_fire) begin
                cnt_q <= (in_last || at_limit) ? '0 : cnt_q + 1'b1;
            end
            if (cut_now) begin
                discard <= 1'b1;
            end else if (discard && byte_fire && in_last) begin
                discard <= 1'b0;
            end
        end
    end

    p_err_single_r7: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(MAX_BYTES));
endmodule

// File: rtl/pkr_lane_fill.sv
module pkr_lane_fill
    import pkr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             align_en,
    input  logic             pay_fire,
    input  logic [LANE_W-1:0] in_data,
    input  logic             in_last,
    input  logic             at_limit,
    output logic             close,
    output pkr_word_t        word
);
    lane_idx_t lane_q;
    logic      fresh_q;
    logic      sop_q;
    lane_idx_t wr_lane;
    logic      eop_now;
    logic [LANES-1:0][LANE_W-1:0] acc_q;

    assign eop_now = in_last || at_limit;
    assign wr_lane = fresh_q ? (align_en ? lane_idx_t'(FILL_LANES) : '0) : lane_q;
    assign close   = pay_fire && ((wr_lane == lane_idx_t'(LANES - 1)) || eop_now);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[g] <= '0;
            end else if (pay_fire) begin
                if (close) begin
                    acc_q[g] <= '0;
                end else if (wr_lane == lane_idx_t'(g)) begin
                    acc_q[g] <= in_data;
                end
            end
        end
        assign word.data[WORD_W-1-g*LANE_W -: LANE_W] =
            (wr_lane == lane_idx_t'(g)) ? in_data : acc_q[g];
    end

    assign word.sop   = sop_q;
    assign word.eop   = eop_now;
    assign word.empty = eop_now ? unused_lanes(wr_lane) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q  <= '0;
            fresh_q <= 1'b1;
            sop_q   <= 1'b1;
        end else if (pay_fire) begin
            lane_q  <= close ? '0 : wr_lane + 1'b1;
            fresh_q <= close && eop_now;
            if (close) begin
                sop_q <= eop_now;
            end
        end
    end
endmodule

// File: rtl/pkr_out_stage.sv
module pkr_out_stage
    import pkr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  pkr_word_t         word_in,
    input  logic              out_ready,
    output logic              can_load,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output lane_idx_t         out_empty
);
    pkr_word_t held_q;

    assign can_load  = !out_valid || out_ready;
    assign out_data  = held_q.data;
    assign out_sop   = held_q.sop;
    assign out_eop   = held_q.eop;
    assign out_empty = held_q.empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            held_q    <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            held_q    <= word_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_sop) && $stable(out_eop) && $stable(out_empty)));

    p_empty_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eop) |-> (out_empty == '0));
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
    import pkr_pkg::*;
#(
    parameter int MAX_BYTES = 1500
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        align_en,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    input  logic        in_last,
    output logic        in_ready,
    output logic [31:0] out_data,
    output logic        out_sop,
    output logic        out_eop,
    output logic [1:0]  out_empty,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        oversize_err
);
    logic      can_load, discard, at_limit, byte_fire, pay_fire, close;
    pkr_word_t word;

    assign in_ready  = discard || can_load;
    assign byte_fire = in_valid && in_ready;
    assign pay_fire  = byte_fire && !discard;

    pkr_len_guard #(.MAX_BYTES(MAX_BYTES)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .byte_fire(byte_fire),
        .pay_fire (pay_fire),
        .in_last  (in_last),
        .at_limit (at_limit),
        .discard  (discard),
        .err      (oversize_err)
    );

    pkr_lane_fill u_fill (
        .clk     (clk),
        .rst     (rst),
        .align_en(align_en),
        .pay_fire(pay_fire),
        .in_data (in_data),
        .in_last (in_last),
        .at_limit(at_limit),
        .close   (close),
        .word    (word)
    );

    pkr_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .load     (close),
        .word_in  (word),
        .out_ready(out_ready),
        .can_load (can_load),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_sop  (out_sop),
        .out_eop  (out_eop),
        .out_empty(out_empty)
    );

    p_err_eop_r7: assert property (@(posedge clk) disable iff (rst)
        oversize_err |-> (out_valid && out_eop));
endmodule

// File: tb/byte_word_packer_tb.sv
module byte_word_packer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        align_en = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [31:0] out_data;
    logic        out_sop, out_eop, out_valid, oversize_err;
    logic [1:0]  out_empty;
    logic        out_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int rdy_mode = 0;
    bit chk_rdy = 1'b1;
    int err_seen = 0;

    logic [35:0] exp_q[$];
    logic [35:0] act_q[$];

    bit          held_prev = 1'b0;
    logic [35:0] held_word;

    always #4 clk = ~clk;

    byte_word_packer u_dut (
        .clk(clk), .rst(rst), .align_en(align_en),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty),
        .out_valid(out_valid), .out_ready(out_ready), .oversize_err(oversize_err)
    );

    function automatic logic [7:0] pbyte(int sd, int i);
        return 8'(sd + i * 37 + (i >> 8) + 1);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        if (rdy_mode == 0) out_ready <= 1'b1;
        else out_ready <= (cyc % 3) != 0;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (held_prev) begin
                chk(out_valid && {out_data, out_sop, out_eop, out_empty} == held_word,
                    "R8", "word held under stall", {out_data, out_sop, out_eop, out_empty}, held_word);
            end
            held_prev = 1'b0;
            if (out_valid && !out_ready) begin
                held_prev = 1'b1;
                held_word = {out_data, out_sop, out_eop, out_empty};
                if (chk_rdy) chk(!in_ready, "R8", "in_ready during stall", in_ready, 0);
            end
            if (out_valid && out_ready) act_q.push_back({out_data, out_sop, out_eop, out_empty});
            if (oversize_err) err_seen++;
        end
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    task automatic model(int n, bit al, int sd, int lim);
        logic [7:0] b[$];
        int m = (n > lim) ? lim : n;
        if (al) begin b.push_back(8'h00); b.push_back(8'h00); end
        for (int i = 0; i < m; i++) b.push_back(pbyte(sd, i));
        for (int w = 0; w * 4 < b.size(); w++) begin
            logic [31:0] d = '0;
            int k = 0;
            for (int j = 0; j < 4; j++) begin
                if (w * 4 + j < b.size()) begin
                    d[31 - 8 * j -: 8] = b[w * 4 + j];
                    k++;
                end
            end
            exp_q.push_back({d, (w == 0) ? 1'b1 : 1'b0,
                             ((w + 1) * 4 >= b.size()) ? 1'b1 : 1'b0,
                             ((w + 1) * 4 >= b.size()) ? 2'(4 - k) : 2'd0});
        end
    endtask

    task automatic drive(int n, int sd, bit give_last);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = pbyte(sd, i);
            in_last  = give_last && (i == n - 1);
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send(int n, bit al, int sd);
        align_en = al;
        model(n, al, sd, 1500);
        drive(n, sd, 1'b1);
    endtask

    task automatic settle_and_compare(string req, int exp_err);
        repeat (12) @(posedge clk);
        chk(act_q.size() == exp_q.size(), req, "word count", act_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
            chk(act_q[i] == exp_q[i], req, $sformatf("word %0d {data,sop,eop,empty}", i), act_q[i], exp_q[i]);
        chk(err_seen == exp_err, req, "oversize pulses", err_seen, exp_err);
        exp_q.delete();
        act_q.delete();
        err_seen = 0;
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready && !oversize_err, "R9", "reset state {valid,ready,err}",
            {out_valid, in_ready, oversize_err}, 3'b010);
    endtask

    task automatic t_unaligned;
        for (int n = 1; n <= 9; n++) begin
            send(n, 1'b0, n * 11);
            settle_and_compare("R1 R2 R3 R4", 0);
        end
    endtask

    task automatic t_aligned;
        for (int n = 1; n <= 9; n++) begin
            send(n, 1'b1, n * 5);
            settle_and_compare("R5 R3 R4", 0);
        end
    endtask

    task automatic t_backpressure;
        rdy_mode = 1;
        send(13, 1'b0, 3);
        send(7, 1'b1, 9);
        settle_and_compare("R8", 0);
        rdy_mode = 0;
    endtask

    task automatic t_back_to_back;
        send(5, 1'b0, 21);
        send(3, 1'b0, 40);
        send(4, 1'b1, 60);
        settle_and_compare("R9 R2", 0);
    endtask

    task automatic t_limits;
        send(1500, 1'b0, 17);
        settle_and_compare("R6", 0);
        send(1500, 1'b1, 19);
        settle_and_compare("R6", 0);
        chk_rdy = 1'b0;
        send(1507, 1'b0, 23);
        settle_and_compare("R7", 1);
        send(1503, 1'b1, 29);
        send(6, 1'b0, 31);
        settle_and_compare("R7", 1);
        chk_rdy = 1'b1;
    endtask

    task automatic t_reset_partial;
        align_en = 1'b0;
        drive(2, 77, 1'b0);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        send(4, 1'b0, 88);
        settle_and_compare("R9", 0);
    endtask

    initial begin
        t_reset;
        t_unaligned;
        t_aligned;
        t_backpressure;
        t_back_to_back;
        t_limits;
        t_reset_partial;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule